// File: doc/BRIEF.md
# Machine Control Register with Fault Capture

This block holds a processor's 64-bit machine status and control word. Software reads the whole word on a read port and replaces it through a full-width write port with a write enable. Each field has its own write rule. There is a cause code, an operating mode, a predicate bit, an interrupt mask bit, a comment byte, a read-only extension presence mask and a 32-bit save slot.

A fault-entry port moves the register into fault state in a single clock edge. On that edge the current low 32 bits are copied into the save slot, the supplied cause code is loaded, the mode becomes supervisor and interrupts are masked. A supplied comment byte is also loaded when it is marked valid.

The block raises a fault request for two conditions: a software write of a reserved mode value, and an external interrupt that is not masked. It also gives the surrounding core a wake-up signal and the current mode and predicate bits. Instruction decode, pipeline control, register banking and handler dispatch belong to the core.

Top module: `machine_ctrl_reg`

## Requirements
- R1: After a synchronous reset, `sw_rdata` reads as follows: cause 4'b1111 in bits 3:0, mode 2'b01 (supervisor) in bits 5:4, predicate 0 in bit 6, interrupt disable 1 in bit 7, comment 8'h00 in bits 15:8, the extension mask in bits 27:16, zero in bits 31:28 and zero save slot in bits 63:32.
- R2: A software write (`sw_we`=1, no fault entry) loads cause, a legal mode (2'b00 user, 2'b01 supervisor), predicate, interrupt disable, comment and save slot from the same bit positions of `sw_wdata`. The new value is readable from the cycle after the write edge.
- R3: Bits 27:16 always read as the `EXT_PRESENT` parameter ANDed with the defined-bit set (bits 0, 1, 6, 7, 8, 9, 10, 11 of the field). Bits 31:28 always read zero. Software writes change neither.
- R4: A software write whose mode bits are 2'b10 or 2'b11 leaves the mode unchanged and still applies the other fields. From the next cycle `flt_req`=1 with `flt_code`=4'b0100, and this holds until a fault entry with cause 4'b0100.
- R5: With no invalid-state fault pending, `flt_req` equals `irq_req` AND NOT interrupt disable in the same cycle, and `flt_code` is then 4'b1100. `wake` follows `irq_req` regardless of interrupt disable.
- R6: When an invalid-state fault is pending and an unmasked interrupt is also requested, `flt_code` is 4'b0100.
- R7: A fault entry (`flt_enter`=1) sets, as of the next cycle, the save slot to the previous bits 31:0, the cause to `flt_cause`, the mode to 2'b01 and interrupt disable to 1. The predicate bit keeps its value.
- R8: On fault entry the comment field takes `flt_cmt` when `flt_cmt_valid`=1 and keeps its value otherwise.
- R9: When a fault entry and a software write share a cycle, the write is discarded entirely, including any invalid-state fault it would raise.
- R10: Software may write any cause code, including ones with no defined meaning such as 4'b1010, and reads it back unchanged.
- R11: `mode_o` and `pred_o` always equal bits 5:4 and bit 6 of `sw_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 64 | Software write data |
| sw_rdata | output | 64 | Current register value |
| flt_enter | input | 1 | Begin fault entry this cycle |
| flt_cause | input | 4 | Cause code loaded on fault entry |
| flt_cmt_valid | input | 1 | Load `flt_cmt` into the comment field on fault entry |
| flt_cmt | input | 8 | Comment byte for fault entry |
| irq_req | input | 1 | External interrupt request |
| flt_req | output | 1 | A fault is requested |
| flt_code | output | 4 | Cause code of the requested fault |
| wake | output | 1 | Wake-up indication, unaffected by the interrupt mask |
| mode_o | output | 2 | Current operating mode |
| pred_o | output | 1 | Current predicate bit |

## Verification
Register contents, `mode_o` and `pred_o` change one clock edge after a write or a fault entry. The invalid-state request likewise appears one edge after the offending write. The interrupt request and `wake` are combinational and settle in the cycle the request is applied. The bench changes inputs on the falling edge. It samples registered results at the following falling edge, after exactly one rising edge, and samples combinational results a short delay after driving, before any rising edge. Every expected register value comes from a small bench model of the write and fault-entry rules.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    localparam int XLEN    = 64;
    localparam int LOW_W   = 32;
    localparam int EXT_W   = 12;
    localparam int CMT_W   = 8;
    localparam int CAUSE_W = 4;
    localparam int MODE_W  = 2;
    localparam int RSV_W   = LOW_W - EXT_W - CMT_W - CAUSE_W - MODE_W - 2;

    // Extension bits that carry a meaning; the rest read zero.
    localparam logic [EXT_W-1:0] EXT_DEFINED = 12'hFC3;

    localparam logic [MODE_W-1:0] MODE_USER  = 2'b00;
    localparam logic [MODE_W-1:0] MODE_SUPER = 2'b01;

    localparam logic [CAUSE_W-1:0] CAUSE_LD_ALIGN = 4'b0000;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_ALIGN = 4'b0001;
    localparam logic [CAUSE_W-1:0] CAUSE_INV_ST   = 4'b0100;
    localparam logic [CAUSE_W-1:0] CAUSE_PRIV     = 4'b0101;
    localparam logic [CAUSE_W-1:0] CAUSE_UNDEF    = 4'b1000;
    localparam logic [CAUSE_W-1:0] CAUSE_EXT_IRQ  = 4'b1100;
    localparam logic [CAUSE_W-1:0] CAUSE_USR_IRQ  = 4'b1101;
    localparam logic [CAUSE_W-1:0] CAUSE_SVC      = 4'b1110;
    localparam logic [CAUSE_W-1:0] CAUSE_RESET    = 4'b1111;

    // Full register image, most significant field first.
    typedef struct packed {
        logic [LOW_W-1:0]   save;
        logic [RSV_W-1:0]   rsvd;
        logic [EXT_W-1:0]   ext;
        logic [CMT_W-1:0]   cmt;
        logic               id;
        logic               pred;
        logic [MODE_W-1:0]  mode;
        logic [CAUSE_W-1:0] cause;
    } mcr_t;

    // Fields that are held in flops.
    typedef struct packed {
        logic [LOW_W-1:0]   save;
        logic [CMT_W-1:0]   cmt;
        logic               id;
        logic               pred;
        logic [MODE_W-1:0]  mode;
        logic [CAUSE_W-1:0] cause;
    } mcr_state_t;

    localparam mcr_state_t STATE_RESET = '{
        save:  '0,
        cmt:   '0,
        id:    1'b1,
        pred:  1'b0,
        mode:  MODE_SUPER,
        cause: CAUSE_RESET
    };

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return (m == MODE_USER) || (m == MODE_SUPER);
    endfunction

    function automatic mcr_t compose(input mcr_state_t s, input logic [EXT_W-1:0] e);
        mcr_t r;
        r.save  = s.save;
        r.rsvd  = '0;
        r.ext   = e;
        r.cmt   = s.cmt;
        r.id    = s.id;
        r.pred  = s.pred;
        r.mode  = s.mode;
        r.cause = s.cause;
        return r;
    endfunction
endpackage

// File: rtl/mcr_ext_mask.sv
module mcr_ext_mask
    import mcr_pkg::*;
#(
    parameter logic [EXT_W-1:0] EXT_PRESENT = 12'h0C7
) (
    output logic [EXT_W-1:0] ext_o
);
    // One constant per bit: undefined positions are tied low.
    for (genvar i = 0; i < EXT_W; i++) begin : g_bit
        if (EXT_DEFINED[i]) begin : g_def
            assign ext_o[i] = EXT_PRESENT[i];
        end else begin : g_undef
            assign ext_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/mcr_state.sv
module mcr_state
    import mcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  mcr_state_t        wr,
    input  logic              flt_enter,
    input  logic [CAUSE_W-1:0] flt_cause,
    input  logic              flt_cmt_valid,
    input  logic [CMT_W-1:0]  flt_cmt,
    input  logic [LOW_W-1:0]  low_word,
    output mcr_state_t        st,
    output logic              bad_write
);
    logic sw_take;

    assign sw_take   = sw_we && !flt_enter;
    assign bad_write = sw_take && !mode_legal(wr.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= STATE_RESET;
        end else if (flt_enter) begin
            st.save  <= low_word;
            st.cause <= flt_cause;
            st.mode  <= MODE_SUPER;
            st.id    <= 1'b1;
            if (flt_cmt_valid) begin
                st.cmt <= flt_cmt;
            end
        end else if (sw_take) begin
            st.save  <= wr.save;
            st.cause <= wr.cause;
            st.pred  <= wr.pred;
            st.id    <= wr.id;
            st.cmt   <= wr.cmt;
            if (mode_legal(wr.mode)) begin
                st.mode <= wr.mode;
            end
        end
    end

    // R7: the low word present at the entry edge lands in the save slot.
    assert_save_snapshot_R7: assert property (@(posedge clk) disable iff (rst)
        flt_enter |=> (st.save == $past(low_word)));

    // R7: fault entry forces supervisor mode and masks interrupts.
    assert_entry_mode_R7: assert property (@(posedge clk) disable iff (rst)
        flt_enter |=> (st.mode == MODE_SUPER) && st.id && (st.cause == $past(flt_cause)));

    // R4: a reserved mode write leaves the mode unchanged.
    assert_mode_kept_R4: assert property (@(posedge clk) disable iff (rst)
        bad_write |=> $stable(st.mode));

    // R11: the mode field only ever holds a legal encoding.
    assert_mode_legal_R11: assert property (@(posedge clk) disable iff (rst)
        st.mode[1] == 1'b0);
endmodule

// File: rtl/mcr_fault_arb.sv
module mcr_fault_arb
    import mcr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bad_write,
    input  logic               flt_enter,
    input  logic [CAUSE_W-1:0] flt_cause,
    input  logic               irq_req,
    input  logic               irq_masked,
    output logic               flt_req,
    output logic [CAUSE_W-1:0] flt_code,
    output logic               wake
);
    logic inv_pend;
    logic irq_live;

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_pend <= 1'b0;
        end else if (flt_enter && (flt_cause == CAUSE_INV_ST)) begin
            inv_pend <= 1'b0;
        end else if (bad_write) begin
            inv_pend <= 1'b1;
        end
    end

    assign irq_live = irq_req && !irq_masked;
    assign flt_req  = inv_pend || irq_live;
    assign flt_code = inv_pend ? CAUSE_INV_ST : CAUSE_EXT_IRQ;
    assign wake     = irq_req;

    // R4: a rejected mode write produces an invalid-state request next cycle.
    assert_inv_raised_R4: assert property (@(posedge clk) disable iff (rst)
        bad_write |=> flt_req && (flt_code == CAUSE_INV_ST));

    // R5: a masked interrupt never produces a request on its own.
    assert_irq_masked_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_masked && !inv_pend) |-> !flt_req);

    // R4: the pending request persists until its own fault entry.
    assert_inv_held_R4: assert property (@(posedge clk) disable iff (rst)
        (inv_pend && !flt_enter) |=> inv_pend);
endmodule

// File: rtl/machine_ctrl_reg.sv
module machine_ctrl_reg
    import mcr_pkg::*;
#(
    parameter logic [11:0] EXT_PRESENT = 12'h0C7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_we,
    input  logic [63:0] sw_wdata,
    output logic [63:0] sw_rdata,
    input  logic        flt_enter,
    input  logic [3:0]  flt_cause,
    input  logic        flt_cmt_valid,
    input  logic [7:0]  flt_cmt,
    input  logic        irq_req,
    output logic        flt_req,
    output logic [3:0]  flt_code,
    output logic        wake,
    output logic [1:0]  mode_o,
    output logic        pred_o
);
    mcr_t             wimg;
    mcr_t             rimg;
    mcr_state_t       wr;
    mcr_state_t       st;
    logic [EXT_W-1:0] ext_val;
    logic             bad_write;
    logic             unused_wbits;

    assign wimg = mcr_t'(sw_wdata);
    assign wr = '{
        save:  wimg.save,
        cmt:   wimg.cmt,
        id:    wimg.id,
        pred:  wimg.pred,
        mode:  wimg.mode,
        cause: wimg.cause
    };
    assign unused_wbits = ^{wimg.rsvd, wimg.ext};

    mcr_ext_mask #(.EXT_PRESENT(EXT_PRESENT)) u_ext (
        .ext_o (ext_val)
    );

    mcr_state u_state (
        .clk           (clk),
        .rst           (rst),
        .sw_we         (sw_we),
        .wr            (wr),
        .flt_enter     (flt_enter),
        .flt_cause     (flt_cause),
        .flt_cmt_valid (flt_cmt_valid),
        .flt_cmt       (flt_cmt),
        .low_word      (sw_rdata[LOW_W-1:0]),
        .st            (st),
        .bad_write     (bad_write)
    );

    mcr_fault_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .bad_write  (bad_write),
        .flt_enter  (flt_enter),
        .flt_cause  (flt_cause),
        .irq_req    (irq_req),
        .irq_masked (st.id),
        .flt_req    (flt_req),
        .flt_code   (flt_code),
        .wake       (wake)
    );

    assign rimg     = compose(st, ext_val);
    assign sw_rdata = rimg;
    assign mode_o   = rimg.mode;
    assign pred_o   = rimg.pred;

    // R3: the extension field never moves, whatever software writes.
    assert_ext_stable_R3: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> $stable(sw_rdata[27:16]));

    // R9: a write colliding with fault entry leaves the comment as entry decides.
    assert_collide_R9: assert property (@(posedge clk) disable iff (rst)
        (flt_enter && sw_we && !flt_cmt_valid) |=> $stable(sw_rdata[15:8]));
endmodule

// File: tb/machine_ctrl_reg_test.sv
module machine_ctrl_reg_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        sw_we;
    logic [63:0] sw_wdata;
    logic [63:0] sw_rdata;
    logic        flt_enter;
    logic [3:0]  flt_cause;
    logic        flt_cmt_valid;
    logic [7:0]  flt_cmt;
    logic        irq_req;
    logic        flt_req;
    logic [3:0]  flt_code;
    logic        wake;
    logic [1:0]  mode_o;
    logic        pred_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] model;

    localparam logic [11:0] EXT_EXP = 12'h0C3;

    always #4 clk = ~clk;

    machine_ctrl_reg uut (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .flt_enter(flt_enter), .flt_cause(flt_cause),
        .flt_cmt_valid(flt_cmt_valid), .flt_cmt(flt_cmt), .irq_req(irq_req),
        .flt_req(flt_req), .flt_code(flt_code), .wake(wake),
        .mode_o(mode_o), .pred_o(pred_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] m_write(input logic [63:0] cur, input logic [63:0] w);
        logic [63:0] r = cur;
        r[63:32] = w[63:32];
        r[15:6]  = w[15:6];
        r[3:0]   = w[3:0];
        if (w[5] == 1'b0) r[5:4] = w[5:4];
        return r;
    endfunction

    function automatic logic [63:0] m_fault(input logic [63:0] cur, input logic [3:0] c,
                                            input logic cv, input logic [7:0] cm);
        logic [63:0] r = cur;
        r[63:32] = cur[31:0];
        r[3:0]   = c;
        r[5:4]   = 2'b01;
        r[7]     = 1'b1;
        if (cv) r[15:8] = cm;
        return r;
    endfunction

    task automatic step();
        @(negedge clk);
        sw_we = 1'b0;
        flt_enter = 1'b0;
        flt_cmt_valid = 1'b0;
    endtask

    task automatic sw_write(input logic [63:0] w);
        sw_we = 1'b1;
        sw_wdata = w;
        model = m_write(model, w);
        step();
    endtask

    task automatic enter(input logic [3:0] c, input logic cv, input logic [7:0] cm);
        flt_enter = 1'b1;
        flt_cause = c;
        flt_cmt_valid = cv;
        flt_cmt = cm;
        model = m_fault(model, c, cv, cm);
        step();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        #1;
        model = {32'h0, 4'h0, EXT_EXP, 8'h00, 1'b1, 1'b0, 2'b01, 4'hF};
        chk("R1 reset value", sw_rdata, model);
        chk("R3 ext after reset", {52'h0, sw_rdata[27:16]}, {52'h0, EXT_EXP});
        chk("R1 no request after reset", {63'h0, flt_req}, 64'h0);
    endtask

    task automatic t_write();
        sw_write({32'hDEAD_BEEF, 4'hF, 12'hFFF, 8'hA5, 1'b0, 1'b1, 2'b00, 4'h3});
        chk("R2 write fields", sw_rdata, model);
        chk("R3 ext and reserved unchanged", {32'h0, sw_rdata[31:16], 16'h0},
            {32'h0, 4'h0, EXT_EXP, 16'h0});
        chk("R11 mode/pred outputs", {61'h0, mode_o, pred_o}, {61'h0, sw_rdata[5:4], sw_rdata[6]});
        sw_write({32'h1234_5678, 4'h0, 12'h000, 8'h5A, 1'b0, 1'b0, 2'b01, 4'hA});
        chk("R10 undefined cause readback", {60'h0, sw_rdata[3:0]}, {60'h0, 4'hA});
        chk("R2 second write", sw_rdata, model);
        chk("R11 mode/pred after second write", {61'h0, mode_o, pred_o}, {61'h0, 2'b01, 1'b0});
    endtask

    task automatic t_irq();
        irq_req = 1'b1;
        #1;
        chk("R5 unmasked irq request", {59'h0, flt_req, flt_code}, {59'h0, 1'b1, 4'b1100});
        chk("R5 wake unmasked", {63'h0, wake}, 64'h1);
        irq_req = 1'b0;
        sw_write(model | 64'h80);
        irq_req = 1'b1;
        #1;
        chk("R5 masked irq no request", {63'h0, flt_req}, 64'h0);
        chk("R5 wake while masked", {63'h0, wake}, 64'h1);
        irq_req = 1'b0;
        sw_write(model & ~64'h80);
    endtask

    task automatic t_badmode();
        sw_write({model[63:16], 8'h3C, 1'b0, 1'b1, 2'b10, 4'h2});
        chk("R4 mode kept, others applied", sw_rdata, model);
        chk("R4 invalid-state request", {59'h0, flt_req, flt_code}, {59'h0, 1'b1, 4'b0100});
        irq_req = 1'b1;
        #1;
        chk("R6 invalid-state before irq", {59'h0, flt_req, flt_code}, {59'h0, 1'b1, 4'b0100});
        irq_req = 1'b0;
        step();
        chk("R4 request held", {59'h0, flt_req, flt_code}, {59'h0, 1'b1, 4'b0100});
        enter(4'b0100, 1'b0, 8'h00);
        chk("R7 fault entry image", sw_rdata, model);
        chk("R4 request cleared by entry", {63'h0, flt_req}, 64'h0);
    endtask

    task automatic t_comment();
        enter(4'b1110, 1'b1, 8'h77);
        chk("R8 comment loaded", sw_rdata, model);
        enter(4'b0000, 1'b0, 8'h99);
        chk("R8 comment kept", sw_rdata, model);
        chk("R7 predicate kept", {63'h0, pred_o}, {63'h0, model[6]});
    endtask

    task automatic t_collide();
        sw_write({model[63:16], 8'h11, 1'b0, 1'b1, 2'b00, 4'h5});
        sw_we = 1'b1;
        sw_wdata = {32'hFFFF_FFFF, 16'h0, 8'hEE, 1'b0, 1'b0, 2'b11, 4'h0};
        enter(4'b1110, 1'b0, 8'h00);
        chk("R9 entry wins over write", sw_rdata, model);
        chk("R9 no invalid-state from dropped write", {63'h0, flt_req}, 64'h0);
    endtask

    initial begin
        rst = 1'b1; sw_we = 1'b0; sw_wdata = '0; flt_enter = 1'b0;
        flt_cause = '0; flt_cmt_valid = 1'b0; flt_cmt = '0; irq_req = 1'b0;
        model = '0;
        @(negedge clk);
        t_reset();
        t_write();
        t_irq();
        t_badmode();
        t_comment();
        t_collide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule